// File: doc/BRIEF.md
# Supply-Dip Reset Pulse Generator

This block turns a digital "supply good" level into an internal active-high reset pulse of fixed length. The supply-good level stands in for the output of a comparator that watches a supply rail against its trip level.

The block fires a pulse the first time the supply comes up. After that, it fires a new pulse only when the supply has been below its trip level for longer than a minimum low width and has then recovered. Dips that are no longer than that width are filtered out and cause no reset.

The supply-good input is asynchronous. It passes through a flop synchronizer before any logic uses it. Both the pulse length and the minimum low width are counted in clock cycles and set by parameters. A qualified recovery that arrives while a pulse is still running reloads the pulse, so the pulse never ends early.

Top module: `por_dip_reset_gen`

## Requirements
- R1: While `rst_n` is low, and after its release for as long as `supply_ok_i` stays low, `por_o` is 0.
- R2: `supply_ok_i` passes through `SYNC_STAGES` (default 2) synchronizer flops. With two stages, a qualifying rise of `supply_ok_i` sets `por_o` to 1 on the third rising clock edge after the rise. The first rise after reset always qualifies.
- R3: Once it is set, `por_o` stays 1 for exactly `PULSE_LEN` clock cycles and then returns to 0, unless R7 reloads it.
- R4: If the synchronized supply is low for more than `MIN_LOW` consecutive clock edges, its next rise produces a new pulse with the latency of R2.
- R5: A dip of `MIN_LOW` or fewer consecutive low clock edges produces no pulse. This includes a dip of exactly `MIN_LOW` edges.
- R6: `por_o` never goes from 0 to 1 while the synchronized supply is low. A long dip keeps `por_o` at 0 until the supply recovers.
- R7: A dip that starts during a pulse does not shorten it. If that dip qualifies, its recovery reloads the pulse so that `por_o` stays 1 until `PULSE_LEN` cycles after the new setting edge.
- R8: Any synchronized high cycle restarts dip qualification. Two short dips separated by a single high cycle do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Asynchronous supply-above-trip level, 1 = good |
| por_o | output | 1 | Active-high internal reset pulse |

## Verification
The assertions check several rules on every cycle:
- a pulse rises only on a synchronized high level (R2);
- the output cannot rise while the synchronized level is low (R6);
- every completed pulse lasted at least `PULSE_LEN` cycles (R3);
- each rise of the synchronized level either triggers a pulse or is filtered, according to the measured length of the preceding dip (R4, R5).

The bench scenarios cover what those rules cannot see:
- the exact three-edge latency from the raw input;
- the exact end cycle of each pulse;
- dips of one below, exactly at and one above the threshold width;
- non-accumulation of split dips;
- the reload of a running pulse.

// File: rtl/por_dip_pkg.sv
// Package: shared types and width helpers for the supply-dip reset pulse generator.
// Assumes: counter limits are non-negative integers known at elaboration.
package por_dip_pkg;

    // Dip qualifier state: idle after a consumed rise, armed after a long low.
    typedef enum logic {
        QUAL_IDLE  = 1'b0,
        QUAL_ARMED = 1'b1
    } qual_e;

    // Width needed to hold values 0..maxval, never less than one bit.
    function automatic int cnt_width(input int maxval);
        int w;
        w = $clog2(maxval + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/por_sync.sv
// Module: por_sync
// Brings the asynchronous supply-good level into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 1. The reset value of 0 means
// "supply below trip".
module por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_i;
            end
        end else begin : g_next
            // Later stages: shift the level one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/por_dip_filter.sv
// Module: por_dip_filter
// Measures runs of low synchronized supply. A run longer than MIN_LOW edges
// arms the filter. The next high level then requests one pulse and disarms
// the filter. The filter starts armed after reset, so the first power-up
// rise always fires. Assumes lvl_i is already synchronous to clk.
module por_dip_filter
    import por_dip_pkg::*;
#(
    parameter int MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fire_o
);

    localparam int LOW_W = cnt_width(MIN_LOW + 1);
    localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(MIN_LOW);

    logic [LOW_W-1:0] low_cnt;
    qual_e            qual_q;

    // Fire request: the level is high while the filter is armed.
    assign fire_o = lvl_i && (qual_q == QUAL_ARMED);

    // Low-run counter: clears on any high cycle and saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (lvl_i)            low_cnt <= '0;
        else if (low_cnt != LOW_LIM) low_cnt <= low_cnt + 1'b1;
    end

    // Arm state: armed by a low edge seen with the count at its limit,
    // disarmed once the fire request is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)                           qual_q <= QUAL_ARMED;
        else if (fire_o)                      qual_q <= QUAL_IDLE;
        else if (!lvl_i && low_cnt == LOW_LIM) qual_q <= QUAL_ARMED;
    end

endmodule

// File: rtl/por_stretch.sv
// Module: por_stretch
// Stretches each fire request into a registered pulse of PULSE_LEN cycles.
// A request that arrives during a pulse reloads the count, so the pulse is
// extended and never cut short. Assumes PULSE_LEN >= 1.
module por_stretch
    import por_dip_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int CNT_W = cnt_width(PULSE_LEN);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_LEN - 1);

    logic [CNT_W-1:0] remain;
    logic             pulse_q;

    // Remaining-cycle counter and registered output flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            pulse_q <= 1'b0;
        end else if (fire_i) begin
            remain  <= RELOAD;
            pulse_q <= 1'b1;
        end else if (remain != '0) begin
            remain  <= remain - 1'b1;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/por_dip_reset_gen.sv
// Module: por_dip_reset_gen (top)
// Supply-dip reset pulse generator. The chain is: synchronizer, then dip
// qualifier, then pulse stretcher. Assumes clk is free-running, SYNC_STAGES
// >= 1 and PULSE_LEN >= 1.
module por_dip_reset_gen #(
    parameter int PULSE_LEN   = 16,
    parameter int MIN_LOW     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic por_o
);

    logic supply_sync;
    logic fire;

    por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (supply_ok_i),
        .q_o   (supply_sync)
    );

    por_dip_filter #(.MIN_LOW(MIN_LOW)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (supply_sync),
        .fire_o (fire)
    );

    por_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .pulse_o (por_o)
    );

endmodule

// File: rtl/por_dip_reset_gen_chk.sv
// Module: por_dip_reset_gen_chk
// Checker bound to the top. It watches the synchronized level and the pulse
// output, using its own run counters to measure dip and pulse lengths.
module por_dip_reset_gen_chk
    import por_dip_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int MIN_LOW   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic lvl,
    input logic por_o
);

    localparam int HI_W = cnt_width(PULSE_LEN);
    localparam int LO_W = cnt_width(MIN_LOW + 1);
    localparam logic [HI_W-1:0] HI_SAT = HI_W'(PULSE_LEN);
    localparam logic [LO_W-1:0] LO_SAT = LO_W'(MIN_LOW + 1);
    localparam logic [LO_W-1:0] LO_LIM = LO_W'(MIN_LOW);

    logic [HI_W-1:0] hi_run;
    logic [LO_W-1:0] lo_run;

    // Length of the current high run of por_o, saturating at PULSE_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_run <= '0;
        else if (!por_o)             hi_run <= '0;
        else if (hi_run != HI_SAT)   hi_run <= hi_run + 1'b1;
    end

    // Length of the current low run of the level; it counts as qualified after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lo_run <= LO_SAT;
        else if (lvl)                lo_run <= '0;
        else if (lo_run != LO_SAT)   lo_run <= lo_run + 1'b1;
    end

    // R2: the pulse starts only after a synchronized high level.
    assert_rise_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_o) |-> $past(lvl));

    // R3: every finished pulse lasted at least PULSE_LEN cycles.
    assert_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_o) |-> (hi_run == HI_SAT));

    // R4: recovery after a long dip produces (or reloads) a pulse.
    assert_long_dip_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl) && lo_run > LO_LIM) |=> por_o);

    // R5: recovery after a short dip leaves an idle output idle.
    assert_short_dip_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl) && lo_run <= LO_LIM && !por_o) |=> !por_o);

    // R6: no pulse can start while the synchronized supply is low.
    assert_no_rise_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !por_o) |=> !por_o);

endmodule

bind por_dip_reset_gen por_dip_reset_gen_chk #(
    .PULSE_LEN (PULSE_LEN),
    .MIN_LOW   (MIN_LOW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (supply_sync),
    .por_o (por_o)
);

// File: tb/por_dip_reset_gen_test.sv
// Bench: drives the input on falling edges, samples por_o on falling edges,
// and computes the expected pulse windows arithmetically.
module por_dip_reset_gen_test;

    localparam int P = 12;   // pulse length
    localparam int M = 3;    // minimum low width

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic por;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    por_dip_reset_gen #(.PULSE_LEN(P), .MIN_LOW(M), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .por_o       (por)
    );

    // Compare one sample of por_o against the expected value.
    task automatic chk(input logic exp, input string req);
        checks++;
        if (por !== exp) begin
            errors++;
            $display("FAIL %s: por_o=%0b expected %0b at %0t", req, por, exp, $time);
        end
    endtask

    // After a rise driven at this negedge, sample the fixed window.
    // A qualified rise gives a pulse on samples 3..P+2.
    task automatic watch_rise(input bit qual, input string req);
        for (int j = 1; j <= P + 4; j++) begin
            @(negedge clk);
            chk(qual && j >= 3 && j <= P + 2, req);
        end
    endtask

    // Hold the supply low for len edges (output must stay low), then recover.
    task automatic dip(input int len, input string req);
        supply_ok = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            chk(1'b0, "R6");
        end
        supply_ok = 1'b1;
        watch_rise(len > M, req);
    endtask

    // Pulse followed by a dip of dlen starting at sample 4. The expected
    // pulse ends at endj.
    task automatic dip_in_pulse(input int dlen, input int endj, input string req);
        supply_ok = 1'b0;
        repeat (M + 1) @(negedge clk);
        supply_ok = 1'b1;
        for (int j = 1; j <= endj + 4; j++) begin
            @(negedge clk);
            chk(j >= 3 && j <= endj, req);
            if (j == 4)        supply_ok = 1'b0;
            if (j == 4 + dlen) supply_ok = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(1'b0, "R1");
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(1'b0, "R1");
        end
        // First power-up rise: latency and length.
        supply_ok = 1'b1;
        watch_rise(1'b1, "R2 R3");
        // Dip widths around the threshold: below, at, and above it.
        for (int len = 1; len <= M + 3; len++)
            dip(len, (len > M) ? "R4" : "R5");
        dip(M - 1, "R5");
        dip(M, "R5");
        dip(M + 1, "R4");
        dip(20, "R6");
        // Two short dips separated by one high cycle must not add up.
        supply_ok = 1'b0;
        repeat (M) @(negedge clk);
        supply_ok = 1'b1;
        @(negedge clk);
        chk(1'b0, "R8");
        supply_ok = 1'b0;
        repeat (M) @(negedge clk);
        supply_ok = 1'b1;
        watch_rise(1'b0, "R8");
        // Short dip inside a pulse: the pulse is neither cut short nor extended.
        dip_in_pulse(2, P + 2, "R7");
        // Qualified dip inside a pulse: recovery at sample 4+M+1 reloads the pulse.
        dip_in_pulse(M + 1, 4 + M + 1 + P + 2, "R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a run that hangs counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule